// File: doc/BRIEF.md
# Byte-Coded Parallel-Port Coprocessor

This block sits on the peripheral end of a byte-wide, strobe-and-wait parallel bus. While idle it listens for host write cycles and puts each incoming byte into the next slot of an eight-byte local store. When the eighth byte lands, the block stops listening and runs the store as a program of 8-bit instructions, starting at address 0. The same store holds the program's data.

The instruction set has no branches. The program counter steps by one after each instruction. The instructions are:
- shifting a store location left or right;
- adding one location into another;
- copying the switch bank into a location;
- two wait instructions, each of which lights an indicator and holds until a chosen push button is pressed;
- a send instruction.

A send raises an interrupt toward the host. When the host answers with a read strobe, the block turns the bus around and drives the chosen byte.

The block re-enters receive mode, with its write address back at 0, in two cases: after the instruction at the last address has run, or after a send has been read.

Top module: `bytecop`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `intr_o`, `bus_oe_o`, `wait_o`, `prime_led_o` and `carry_o` are all 0.
- R2: In receive mode, a cycle with `strobe_n_i` and `write_n_i` both low stores `bus_d_i` at the current write address and advances that address by one. `wait_o` is then high until the host raises `strobe_n_i`. After the eighth byte's strobe is released, execution begins at address 0.
- R3: An instruction whose bits [7:6] are 00 shifts the location named by bits [5:3] left by one, filling the low bit with 0. When bits [7:6] are 01, it shifts that location right by one, filling the high bit with 0. In both cases `carry_o` takes the bit that was shifted out.
- R4: When bits [7:6] are 10, the location named by bits [5:3] is replaced by the 8-bit sum of itself and the location named by bits [2:0]. `carry_o` takes the carry out of the sum.
- R5: When bits [7:4] are 1100, the value on `switch_i` is written to the location named by bits [2:0]. `carry_o` is left unchanged.
- R6: When bits [7:4] are 1101, `prime_led_o` goes high and execution halts until the left button is pressed. When bits [7:4] are 1110, the same happens with the right button. A press of the other button has no effect, and each press releases exactly one wait instruction.
- R7: When bits [7:4] are 1111, the location named by bits [2:0] is selected and `intr_o` is raised, but only while `write_n_i` is high. A host read cycle (`strobe_n_i` low with `write_n_i` high) then causes the block to drive the byte on `bus_d_o` with `bus_oe_o` and `wait_o` high, holding it steady until the strobe is released.
- R8: The program counter rises by one after each instruction. After the instruction at address 7, or after a completed send, the block returns to receive mode, and the next byte it receives is stored at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, shared with the host side of the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n_i | input | 1 | Host data strobe, active low |
| write_n_i | input | 1 | Host cycle direction: low for a write to the block, high for a read |
| bus_d_i | input | DATA_W | Data lines as seen from the bus |
| bus_d_o | output | DATA_W | Data the block drives during a read cycle |
| bus_oe_o | output | 1 | Output enable for the bus data lines |
| wait_o | output | 1 | Handshake: high means the host may end its strobe |
| intr_o | output | 1 | Interrupt to the host: a result byte is ready |
| btn_left_i | input | 1 | Left push button, asynchronous |
| btn_right_i | input | 1 | Right push button, asynchronous |
| switch_i | input | DATA_W | Switch bank value |
| prime_led_o | output | 1 | Indicator lit while a wait instruction holds |
| carry_o | output | 1 | Carry flag from the last shift or add |

## Verification
The bench builds the block with its default values: an 8-bit data path and a two-stage button synchronizer. These values let each pushed button reach the wait logic within three clocks, so the bench can show that a press on the wrong button is ignored. The bench can also show that a single press clears only one of two back-to-back wait instructions. The programs it loads cover the following:
- shifts and adds, with and without a carry out;
- a switch capture that must hold an old switch value after the switches change;
- a program that runs off the end of the store without sending;
- a host that holds its write line low while a send is pending.

// File: rtl/bytecop_pkg.sv
// Shared types for the byte-coded coprocessor: control states and the
// decoded instruction class. Assumes an 8-bit instruction byte.
package bytecop_pkg;

    typedef enum logic [2:0] {
        ST_RECV,       // waiting for a host write strobe
        ST_RECV_HOLD,  // byte taken, waiting for strobe release
        ST_EXEC,       // executing the instruction at pc
        ST_PRIME,      // held by a wait instruction
        ST_IRQ,        // result selected, interrupt pending
        ST_DRIVE       // driving the result during a host read
    } state_t;

    typedef enum logic [2:0] {
        OP_SHL,
        OP_SHR,
        OP_ADD,
        OP_GRAB,
        OP_WAIT_L,
        OP_WAIT_R,
        OP_SEND
    } op_t;

    // Map an instruction byte to its class; top two bits first, then bits 5..4.
    function automatic op_t decode_op(input logic [7:0] ins);
        op_t r;
        case (ins[7:6])
            2'b00:   r = OP_SHL;
            2'b01:   r = OP_SHR;
            2'b10:   r = OP_ADD;
            default: begin
                case (ins[5:4])
                    2'b00:   r = OP_GRAB;
                    2'b01:   r = OP_WAIT_L;
                    2'b10:   r = OP_WAIT_R;
                    default: r = OP_SEND;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bytecop_btn_edge.sv
// Push-button front end: synchronizes an asynchronous button level and
// emits a one-cycle pulse on each rising edge. Assumes SYNC_STAGES >= 2
// and that the button is debounced outside this block.
module bytecop_btn_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic press_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw level through the synchronizer and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign press_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    AST_PRESS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o);  // R6

endmodule

// File: rtl/bytecop_alu.sv
// Datapath for one instruction: shift, add or switch capture. Purely
// combinational; the caller decides whether the result and carry are kept.
module bytecop_alu
    import bytecop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_t               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] sw_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              carry_we_o
);

    // Compute the result byte and the carry for the decoded class.
    always_comb begin
        res_o      = a_i;
        carry_o    = 1'b0;
        carry_we_o = 1'b0;
        case (op_i)
            OP_SHL: begin
                {carry_o, res_o} = {a_i, 1'b0};
                carry_we_o       = 1'b1;
            end
            OP_SHR: begin
                res_o      = {1'b0, a_i[DATA_W-1:1]};
                carry_o    = a_i[0];
                carry_we_o = 1'b1;
            end
            OP_ADD: begin
                {carry_o, res_o} = {1'b0, a_i} + {1'b0, b_i};
                carry_we_o       = 1'b1;
            end
            OP_GRAB: res_o = sw_i;
            default: ;
        endcase
    end

endmodule

// File: rtl/bytecop.sv
// Byte-coded coprocessor top. It fills an 8-byte store from host write cycles,
// then runs that store as straight-line 8-bit code, and returns results
// through an interrupt-started read cycle. Assumes the host bus is
// synchronous to clk and that the host drives bus_d_i only while writing.
module bytecop
    import bytecop_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n_i,
    input  logic              write_n_i,
    input  logic [DATA_W-1:0] bus_d_i,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_oe_o,
    output logic              wait_o,
    output logic              intr_o,
    input  logic              btn_left_i,
    input  logic              btn_right_i,
    input  logic [DATA_W-1:0] switch_i,
    output logic              prime_led_o,
    output logic              carry_o
);

    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NBTN   = 2;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    state_t              state_q;
    logic [DATA_W-1:0]   mem_q [DEPTH];
    logic [ADDR_W-1:0]   wp_q;
    logic [ADDR_W-1:0]   pc_q;
    logic [ADDR_W-1:0]   sel_q;
    logic                btn_sel_q;
    logic                carry_q;

    logic [DATA_W-1:0]   instr;
    op_t                 op;
    logic [ADDR_W-1:0]   xa, xb, dest;
    logic [DATA_W-1:0]   alu_res;
    logic                alu_carry, alu_carry_we;
    logic                rx_take, mem_we, at_last;
    logic [NBTN-1:0]     btn_raw, press;

    assign instr   = mem_q[pc_q];
    assign op      = decode_op(instr[7:0]);
    assign xa      = instr[5:3];
    assign xb      = instr[2:0];
    assign dest    = (op == OP_GRAB) ? xb : xa;
    assign at_last = (pc_q == LAST_ADDR);
    assign rx_take = (state_q == ST_RECV) && !strobe_n_i && !write_n_i;
    assign mem_we  = (state_q == ST_EXEC) &&
                     (op == OP_SHL || op == OP_SHR || op == OP_ADD || op == OP_GRAB);

    // One synchronizer and edge detector per push button; index 0 is left.
    assign btn_raw = {btn_right_i, btn_left_i};
    for (genvar g = 0; g < NBTN; g++) begin : g_btn
        bytecop_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .btn_i   (btn_raw[g]),
            .press_o (press[g])
        );
    end

    bytecop_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i       (op),
        .a_i        (mem_q[xa]),
        .b_i        (mem_q[xb]),
        .sw_i       (switch_i),
        .res_o      (alu_res),
        .carry_o    (alu_carry),
        .carry_we_o (alu_carry_we)
    );

    // Shared code/data store: host writes in receive mode, results in execute mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (rx_take) begin
            mem_q[wp_q] <= bus_d_i;
        end else if (mem_we) begin
            mem_q[dest] <= alu_res;
        end
    end

    // Control sequencer: receive, execute, wait on buttons, and return results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RECV;
            wp_q      <= '0;
            pc_q      <= '0;
            sel_q     <= '0;
            btn_sel_q <= 1'b0;
            carry_q   <= 1'b0;
        end else begin
            if (state_q == ST_EXEC && alu_carry_we) carry_q <= alu_carry;
            case (state_q)
                ST_RECV: begin
                    if (rx_take) begin
                        wp_q    <= wp_q + 1'b1;
                        state_q <= ST_RECV_HOLD;
                    end
                end
                ST_RECV_HOLD: begin
                    if (strobe_n_i) begin
                        pc_q    <= '0;
                        state_q <= (wp_q == '0) ? ST_EXEC : ST_RECV;
                    end
                end
                ST_EXEC: begin
                    if (op == OP_WAIT_L || op == OP_WAIT_R) begin
                        btn_sel_q <= (op == OP_WAIT_R);
                        state_q   <= ST_PRIME;
                    end else if (op == OP_SEND) begin
                        sel_q   <= xb;
                        state_q <= ST_IRQ;
                    end else if (at_last) begin
                        wp_q    <= '0;
                        state_q <= ST_RECV;
                    end else begin
                        pc_q <= pc_q + 1'b1;
                    end
                end
                ST_PRIME: begin
                    if (press[btn_sel_q]) begin
                        if (at_last) begin
                            wp_q    <= '0;
                            state_q <= ST_RECV;
                        end else begin
                            pc_q    <= pc_q + 1'b1;
                            state_q <= ST_EXEC;
                        end
                    end
                end
                ST_IRQ: begin
                    if (!strobe_n_i && write_n_i) state_q <= ST_DRIVE;
                end
                ST_DRIVE: begin
                    if (strobe_n_i) begin
                        wp_q    <= '0;
                        state_q <= ST_RECV;
                    end
                end
                default: state_q <= ST_RECV;
            endcase
        end
    end

    assign wait_o      = (state_q == ST_RECV_HOLD) || (state_q == ST_DRIVE);
    assign bus_oe_o    = (state_q == ST_DRIVE);
    assign bus_d_o     = bus_oe_o ? mem_q[sel_q] : '0;
    assign intr_o      = (state_q == ST_IRQ) && write_n_i;
    assign prime_led_o = (state_q == ST_PRIME);
    assign carry_o     = carry_q;

    AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |=> (wp_q == $past(wp_q) + 1'b1));  // R2
    AST_EXEC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV_HOLD && strobe_n_i && wp_q == '0) |=> (state_q == ST_EXEC && pc_q == '0));  // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !at_last) |=> (pc_q == $past(pc_q) + 1'b1));  // R8
    AST_PRIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prime_led_o && !press[btn_sel_q]) |=> prime_led_o);  // R6
    AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_d_o));  // R7
    AST_SEND_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && strobe_n_i) |=> (state_q == ST_RECV && wp_q == '0));  // R8

endmodule

// File: tb/bytecop_tb_top.sv
// Scoreboard bench: each program load pushes its expected result bytes into
// a queue; a monitor pops one whenever the block begins driving the bus.
module bytecop_tb_top;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              strobe_n, write_n;
    logic [DATA_W-1:0] bus_din;
    logic [DATA_W-1:0] bus_dout;
    logic              bus_oe, wait_s, intr_s;
    logic              btn_l, btn_r;
    logic [DATA_W-1:0] sw;
    logic              led, carry;

    int n_checks = 0;
    int n_err    = 0;

    logic [7:0] exp_val [$];
    string      exp_req [$];
    logic [7:0] prog [8];
    logic       oe_prev = 1'b0;

    always #5 clk = ~clk;

    bytecop #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_n_i  (strobe_n),
        .write_n_i   (write_n),
        .bus_d_i     (bus_din),
        .bus_d_o     (bus_dout),
        .bus_oe_o    (bus_oe),
        .wait_o      (wait_s),
        .intr_o      (intr_s),
        .btn_left_i  (btn_l),
        .btn_right_i (btn_r),
        .switch_i    (sw),
        .prime_led_o (led),
        .carry_o     (carry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Driver side of the scoreboard.
    task automatic expect_send(input logic [7:0] v, input string req);
        exp_val.push_back(v);
        exp_req.push_back(req);
    endtask

    // Host write of the eight program bytes.
    task automatic load_program();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_din  = prog[i];
            write_n  = 1'b0;
            strobe_n = 1'b0;
            @(negedge clk);
            chk("R2 wait after write strobe", wait_s, 1'b1);
            while (!wait_s) @(negedge clk);
            strobe_n = 1'b1;
            write_n  = 1'b1;
            @(negedge clk);
            while (wait_s) @(negedge clk);
        end
    endtask

    // Host read cycle answering the interrupt.
    task automatic host_read();
        while (!intr_s) @(negedge clk);
        strobe_n = 1'b0;
        @(negedge clk);
        while (!wait_s) @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        while (wait_s) @(negedge clk);
    endtask

    task automatic press(input bit right);
        @(negedge clk);
        if (right) btn_r = 1'b1; else btn_l = 1'b1;
        repeat (4) @(negedge clk);
        btn_r = 1'b0;
        btn_l = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Monitor side: compare on the first cycle of each bus drive.
    always @(negedge clk) begin
        if (bus_oe && !oe_prev) begin
            if (exp_val.size() == 0) begin
                n_checks++;
                n_err++;
                $display("FAIL R7 unexpected send: actual %0h expected none", bus_dout);
            end else begin
                chk(exp_req.pop_front(), bus_dout, exp_val.pop_front());
            end
        end
        oe_prev = bus_oe;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; strobe_n = 1'b1; write_n = 1'b1; bus_din = '0;
        btn_l = 1'b0; btn_r = 1'b0; sw = '0;
        repeat (3) @(negedge clk);
        chk("R1 intr in reset", intr_s, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 intr", intr_s, 1'b0);
        chk("R1 oe", bus_oe, 1'b0);
        chk("R1 wait", wait_s, 1'b0);
        chk("R1 led", led, 1'b0);
        chk("R1 carry", carry, 1'b0);

        // P1 (R4, R3): add 6+7 into 6, shift 6 left, send 6; host holds write_n low.
        prog = '{8'hB7, 8'h30, 8'hF6, 8'h00, 8'h00, 8'h00, 8'h15, 8'h22};
        expect_send(8'h6E, "R4 add then R3 shift left");
        load_program();
        write_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 no interrupt during host write", intr_s, 1'b0);
        write_n = 1'b1;
        @(negedge clk);
        chk("R7 interrupt once write released", intr_s, 1'b1);
        chk("R4 carry clear on small add", carry, 1'b0);
        host_read();

        // P2 (R3): shift right of 0x81, then send it.
        prog = '{8'h78, 8'hF7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h81};
        expect_send(8'h40, "R3 shift right");
        load_program();
        while (!intr_s) @(negedge clk);
        chk("R3 carry from shifted-out low bit", carry, 1'b1);
        host_read();

        // P3 (R4): 0xC0 + 0x50 overflows.
        prog = '{8'hB7, 8'hF6, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h50};
        expect_send(8'h10, "R4 wrapped sum");
        load_program();
        while (!intr_s) @(negedge clk);
        chk("R4 carry out of add", carry, 1'b1);
        host_read();

        // P4 (R8, R3): eight left shifts, no send; runs off address 7.
        prog = '{8'h38, 8'h38, 8'h38, 8'h38, 8'h38, 8'h38, 8'h38, 8'h38};
        load_program();
        repeat (20) @(negedge clk);
        chk("R8 no interrupt after running off end", intr_s, 1'b0);
        chk("R8 idle wait", wait_s, 1'b0);
        chk("R8 led off", led, 1'b0);
        chk("R3 last shift carry zero", carry, 1'b0);

        // P6 (R8): new transfer lands at address 0 again.
        prog = '{8'hF3, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00};
        expect_send(8'hA5, "R8 write address restarts at 0");
        load_program();
        host_read();

        // P5 (R6, R5): wait left, capture switches, wait right, send.
        prog = '{8'hD0, 8'hC5, 8'hE0, 8'hF5, 8'h00, 8'h00, 8'h00, 8'h00};
        expect_send(8'h5A, "R5 switch capture after R6 left press");
        sw = 8'h33;
        load_program();
        repeat (3) @(negedge clk);
        chk("R6 indicator lit on left wait", led, 1'b1);
        press(1'b1);
        chk("R6 right press ignored on left wait", led, 1'b1);
        chk("R6 no interrupt while waiting", intr_s, 1'b0);
        sw = 8'h5A;
        press(1'b0);
        chk("R6 one press releases only one wait", led, 1'b1);
        chk("R6 still no interrupt", intr_s, 1'b0);
        sw = 8'h11;
        press(1'b1);
        host_read();

        repeat (4) @(negedge clk);
        chk("R7 all expected sends seen", exp_val.size(), 0);
        summary();
        $finish;
    end

endmodule